// File: doc/BRIEF.md
# LCD Backplane and Segment Modulator

This block produces the drive levels for a static liquid crystal display. A square-wave backplane is made either by dividing a fast oscillator tick by 256 or by taking an externally supplied backplane level. Each segment level is the backplane exclusive-ORed with an "on" bit. An on segment therefore sits in antiphase with the backplane, and an off segment stays in phase with it.

The on bits come from the latched data word, or from a fixed pattern that a two-bit test code selects: all off, all on, or alternating. When the power-good input drops, the backplane and every segment are held low, so the panel carries no DC bias. All outputs are registered, so they change only on the system clock and do not glitch when the mode changes.

Top module: `lcd_bp_seg_mod`

## Requirements
- R1: While rst_ni is low, bp_o and every bit of seg_o are 0.
- R2: With ext_sel_i low, bp_o follows bit 7 of an 8-bit counter. The counter starts at 0 and advances once per system clock in which osc_tick_i is high. After 127 ticks bp_o is still 0. The 128th tick sets it to 1, and the 256th tick returns it to 0. Each counter change reaches bp_o one clock after the counter updates.
- R3: With ext_sel_i high, bp_o equals the value ext_bp_i had one clock earlier.
- R4: With test_i = 2'b00 (test_i[1] is the first test bit, test_i[0] the second), seg_o[i] = bp_o XOR seg_data_i[i], where seg_data_i comes from one clock earlier.
- R5: With test_i = 2'b01, every segment equals bp_o, and seg_data_i has no effect.
- R6: With test_i = 2'b10, every segment equals NOT bp_o, and seg_data_i has no effect.
- R7: With test_i = 2'b11, seg_o[i] for even i (odd-numbered segments 1, 3, 5, ...) equals NOT bp_o, and seg_o[i] for odd i equals bp_o.
- R8: When pwr_good_i is low, bp_o and seg_o are 0 on the next clock. Normal output resumes one clock after pwr_good_i returns high.
- R9: The divider counter keeps counting ticks while the external backplane is selected and while the outputs are blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-clock oscillator tick enable |
| ext_sel_i | input | 1 | 1 selects the external backplane |
| ext_bp_i | input | 1 | External backplane level, synchronous to clk_i |
| seg_data_i | input | 38 | Latched segment word, bit i drives segment i+1 |
| test_i | input | 2 | Display mode {first test bit, second test bit} |
| pwr_good_i | input | 1 | Logic supply good; low blanks the outputs |
| bp_o | output | 1 | Backplane level |
| seg_o | output | 38 | Segment levels |

## Verification
The hardest state to reach is the half-period boundary of the divider. The backplane moves only on the 128th tick, so a check made one tick early or late looks identical to a correct result. The stimulus gives exact tick bursts of 127, 1 and 128 and checks the level after each burst. Every pattern check is done once with the backplane at 0 and once at 1. A burst given while the external source is selected shows the counter's hidden phase after switching back to the internal source.

// File: rtl/lcd_mod_pkg.sv
package lcd_mod_pkg;
  localparam int unsigned NUM_SEG = 38;
  localparam int unsigned DIV_W   = 8;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_OFF    = 2'b01,
    MODE_ON     = 2'b10,
    MODE_ALT    = 2'b11
  } disp_mode_e;
endpackage

// File: rtl/lcd_bp_div.sv
module lcd_bp_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic bp_int_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign bp_int_o = cnt_q[DIV_W-1];
endmodule

// File: rtl/lcd_seg_pattern.sv
module lcd_seg_pattern
  import lcd_mod_pkg::*;
#(
  parameter int unsigned N = 38
) (
  input  logic [N-1:0] data_i,
  input  logic [1:0]   mode_i,
  output logic [N-1:0] on_o
);
  logic [N-1:0] alt_pat;

  // segment 1 (index 0) is odd-numbered and lit
  for (genvar g = 0; g < N; g++) begin : g_alt
    assign alt_pat[g] = (g % 2 == 0);
  end

  always_comb begin
    unique case (disp_mode_e'(mode_i))
      MODE_NORMAL: on_o = data_i;
      MODE_OFF:    on_o = '0;
      MODE_ON:     on_o = '1;
      default:     on_o = alt_pat;
    endcase
  end
endmodule

// File: rtl/lcd_out_stage.sv
module lcd_out_stage #(
  parameter int unsigned N = 38
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bp_i,
  input  logic [N-1:0] on_i,
  input  logic         pwr_good_i,
  output logic         bp_o,
  output logic [N-1:0] seg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_o  <= 1'b0;
      seg_o <= '0;
    end else if (!pwr_good_i) begin
      bp_o  <= 1'b0;
      seg_o <= '0;
    end else begin
      bp_o  <= bp_i;
      seg_o <= {N{bp_i}} ^ on_i;
    end
  end
endmodule

// File: rtl/lcd_bp_seg_mod.sv
module lcd_bp_seg_mod
  import lcd_mod_pkg::*;
#(
  parameter int unsigned N_SEG = NUM_SEG,
  parameter int unsigned DW    = DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic             ext_sel_i,
  input  logic             ext_bp_i,
  input  logic [N_SEG-1:0] seg_data_i,
  input  logic [1:0]       test_i,
  input  logic             pwr_good_i,
  output logic             bp_o,
  output logic [N_SEG-1:0] seg_o
);
  logic             bp_int;
  logic             bp_src;
  logic [N_SEG-1:0] on_vec;

  lcd_bp_div #(.DIV_W(DW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (osc_tick_i),
    .bp_int_o(bp_int)
  );

  assign bp_src = ext_sel_i ? ext_bp_i : bp_int;

  lcd_seg_pattern #(.N(N_SEG)) u_pat (
    .data_i(seg_data_i),
    .mode_i(test_i),
    .on_o  (on_vec)
  );

  lcd_out_stage #(.N(N_SEG)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bp_i      (bp_src),
    .on_i      (on_vec),
    .pwr_good_i(pwr_good_i),
    .bp_o      (bp_o),
    .seg_o     (seg_o)
  );
endmodule

// File: rtl/lcd_bp_seg_mod_chk.sv
module lcd_bp_seg_mod_chk #(
  parameter int unsigned N_SEG = 38
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_sel_i,
  input logic             ext_bp_i,
  input logic [N_SEG-1:0] seg_data_i,
  input logic [1:0]       test_i,
  input logic             pwr_good_i,
  input logic             bp_o,
  input logic [N_SEG-1:0] seg_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R1
  rst_out_low_chk: assert property (@(posedge clk_i) !rst_ni |-> (!bp_o && seg_o == '0));

  // R8
  blank_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !pwr_good_i) |=> (!bp_o && seg_o == '0));

  // R3
  ext_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && pwr_good_i && ext_sel_i) |=> (bp_o == $past(ext_bp_i)));

  // R4
  normal_xor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && pwr_good_i && test_i == 2'b00) |=> (seg_o == ({N_SEG{bp_o}} ^ $past(seg_data_i))));

  // R5
  all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && pwr_good_i && test_i == 2'b01) |=> (seg_o == {N_SEG{bp_o}}));

  // R6
  all_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && pwr_good_i && test_i == 2'b10) |=> (seg_o == ~{N_SEG{bp_o}}));

  // R7
  alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && pwr_good_i && test_i == 2'b11) |=> (seg_o[0] != bp_o && seg_o[1] == bp_o));
endmodule

bind lcd_bp_seg_mod lcd_bp_seg_mod_chk #(.N_SEG(N_SEG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ext_sel_i (ext_sel_i),
  .ext_bp_i  (ext_bp_i),
  .seg_data_i(seg_data_i),
  .test_i    (test_i),
  .pwr_good_i(pwr_good_i),
  .bp_o      (bp_o),
  .seg_o     (seg_o)
);

// File: tb/lcd_bp_seg_mod_tb_top.sv
module lcd_bp_seg_mod_tb_top;
  localparam int N = 38;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         osc_tick_i = 1'b0;
  logic         ext_sel_i = 1'b0;
  logic         ext_bp_i = 1'b0;
  logic [N-1:0] seg_data_i = '0;
  logic [1:0]   test_i = 2'b00;
  logic         pwr_good_i = 1'b1;
  logic         bp_o;
  logic [N-1:0] seg_o;

  int n_chk = 0;
  int n_bad = 0;
  logic model_bp = 1'b0;

  always #5 clk_i = ~clk_i;

  lcd_bp_seg_mod dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_tick_i(osc_tick_i),
    .ext_sel_i(ext_sel_i), .ext_bp_i(ext_bp_i), .seg_data_i(seg_data_i),
    .test_i(test_i), .pwr_good_i(pwr_good_i), .bp_o(bp_o), .seg_o(seg_o)
  );

  function automatic logic [N-1:0] exp_seg(logic [1:0] m, logic [N-1:0] d, logic b);
    logic [N-1:0] on;
    case (m)
      2'b00: on = d;
      2'b01: on = '0;
      2'b10: on = '1;
      default: for (int i = 0; i < N; i++) on[i] = (i % 2 == 0);
    endcase
    return {N{b}} ^ on;
  endfunction

  task automatic check(string req, logic [N:0] act, logic [N:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic ticks(int n);
    @(negedge clk_i);
    osc_tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    osc_tick_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R1", {bp_o, seg_o}, '0);
    rst_ni = 1'b1;
    settle();
    check("R1", {bp_o, seg_o}, {1'b0, exp_seg(2'b00, '0, 1'b0)});
  endtask

  task automatic t_divider();
    ticks(127); settle();
    check("R2 after 127", {1'b0, bp_o}, '0);
    ticks(1); settle();
    check("R2 after 128", {1'b0, bp_o}, 1);
    ticks(128); settle();
    check("R2 after 256", {1'b0, bp_o}, '0);
    model_bp = 1'b0;
  endtask

  task automatic t_modes(logic [N-1:0] d);
    for (int m = 0; m < 4; m++) begin
      test_i = m[1:0];
      seg_data_i = d;
      settle();
      check(m == 0 ? "R4" : m == 1 ? "R5" : m == 2 ? "R6" : "R7",
            {bp_o, seg_o}, {model_bp, exp_seg(m[1:0], d, model_bp)});
      if (m != 0) begin
        seg_data_i = ~d;
        settle();
        check(m == 1 ? "R5 data ignored" : m == 2 ? "R6 data ignored" : "R7 data ignored",
              {bp_o, seg_o}, {model_bp, exp_seg(m[1:0], d, model_bp)});
      end
    end
    test_i = 2'b00;
  endtask

  task automatic t_external();
    ext_sel_i = 1'b1;
    ext_bp_i = 1'b1;
    seg_data_i = 38'h15_5555_5555;
    settle();
    check("R3 ext high", {bp_o, seg_o}, {1'b1, exp_seg(2'b00, seg_data_i, 1'b1)});
    ext_bp_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    check("R3 one clock", {1'b0, bp_o}, '0);
    ticks(128); settle();
    check("R9 ext ignores div", {1'b0, bp_o}, '0);
    ext_sel_i = 1'b0;
    settle();
    model_bp = ~model_bp;
    check("R9 div kept counting", {1'b0, bp_o}, {{N{1'b0}}, model_bp});
  endtask

  task automatic t_blank();
    test_i = 2'b10;
    settle();
    check("R6 pre blank", {bp_o, seg_o}, {model_bp, exp_seg(2'b10, '0, model_bp)});
    pwr_good_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    check("R8 blank", {bp_o, seg_o}, '0);
    ticks(128); settle();
    check("R8 held low", {bp_o, seg_o}, '0);
    model_bp = ~model_bp;
    pwr_good_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    check("R8 R9 resume", {bp_o, seg_o}, {model_bp, exp_seg(2'b10, '0, model_bp)});
    test_i = 2'b00;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_divider();
        t_modes(38'h2A_C3F0_0F96);
        ticks(128); model_bp = 1'b1;
        t_modes(38'h15_0FF0_1234);
        t_external();
        t_blank();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hang exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule